// File: doc/BRIEF.md
# Receive Frame Queue with Word-Serial Host Readout

This block holds received Ethernet frames in an on-chip word store and hands them to a host through one 32-bit data register. The receive side delivers a byte stream with a last-byte flag and two error flags. The block packs the bytes into words and reserves a header slot in front of each frame. It counts a frame as pending only once its last byte has been stored.

The host first reads the pending-frame count. It then drains one frame through the data register: a fixed sync word, then a header holding length and error status, then the payload words. A control register gates reception and starts a one-cycle flush that empties the queue. Writing zero to the count register clears the count.

Top module: `rxq_readout`

## Requirements
- R1: The first data-register read of every pending frame returns the sync word 0x0143414D.
- R2: The second read returns the header. Bits 15:0 hold the frame length in bytes. Bit 20 holds the CRC error flag, bits 22:21 hold the two length-error flags, and every other bit of 31:16 is zero.
- R3: The header is followed by ceil(length/4) payload words. Byte k of the frame sits in bits 8*(k mod 4)+7 : 8*(k mod 4) of payload word k/4, and unused bytes of the last word read as zero.
- R4: The count register (address 1) rises by one when a frame's last byte is stored. It falls by one when the host reads that frame's last payload word.
- R5: Writing zero to the count register sets the count to zero. A non-zero write leaves it unchanged.
- R6: With the count at zero, a data-register (address 2) read returns zero and does not advance the readout. The next frame stored is still read from its sync word.
- R7: Writing 1 to bit 3 of the control register (address 0) makes that bit read 1 for exactly one cycle, after which it reads 0. The flush then leaves the count at zero, discards every stored frame, and discards the rest of any frame being received.
- R8: Bit 2 of the control register enables reception and reads back as written, with reset value 0. A frame whose first byte arrives while it is 0 is dropped entirely.
- R9: A frame that does not fit in the free space is dropped entirely. Frames already stored are unaffected, and the space the dropped frame had used is freed for later frames.
- R10: Frames are read out in arrival order, and their contents stay intact when the storage pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte valid |
| in_byte | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_crc_err | input | 1 | CRC error flag, sampled with the final byte |
| in_len_err | input | 2 | Length error flags, sampled with the final byte |
| host_addr | input | 2 | Register select: 0 control, 1 count, 2 data |
| host_rd | input | 1 | Host read strobe (data reads advance on the clock edge) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data (combinational from the selected register) |

## Verification
The bench builds the block with a 16-word store, so a few 12-byte frames fill it completely. This makes both the start-of-frame and the mid-frame overflow paths reachable, and it makes the pointers wrap many times during the sweep. Every frame length from 1 to 24 bytes is sent and read back, which covers every padding position of the last word and all four length-error codes. All sync, header and payload values are computed arithmetically from the length and a seed.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam logic [31:0] RXQ_SYNC_WORD  = 32'h0143_414D;
   localparam int          CTRL_EN_BIT    = 2;
   localparam int          CTRL_FLUSH_BIT = 3;
   localparam int          ST_CRC_BIT     = 4;
   localparam int          ST_LEN_LSB     = 5;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_DATA  = 2'd2,
      SEL_NONE  = 2'd3
   } rxq_sel_e;

   typedef enum logic [1:0] {
      PH_SYNC = 2'd0,
      PH_HDR  = 2'd1,
      PH_DATA = 2'd2
   } rxq_phase_e;

   function automatic logic [15:0] rxq_status(input logic crc, input logic [1:0] lerr);
      logic [15:0] s;
      s = '0;
      s[ST_CRC_BIT]            = crc;
      s[ST_LEN_LSB +: 2]       = lerr;
      return s;
   endfunction

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
   parameter int DEPTH    = 64,
   parameter int PAD_ZERO = 1,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          byte_we,
   input  logic [AW-1:0] byte_addr,
   input  logic [1:0]    byte_lane,
   input  logic [7:0]    byte_data,
   input  logic          hdr_we,
   input  logic [AW-1:0] hdr_addr,
   input  logic [31:0]   hdr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [31:0]   rd_data
);

   for (genvar b = 0; b < 4; b++) begin : g_lane
      logic [7:0] lane_q [DEPTH];
      logic       hit;
      logic       clr;

      assign hit = byte_we && (byte_lane == 2'(b));

      if (PAD_ZERO != 0 && b != 0) begin : g_pad
         assign clr = byte_we && (byte_lane == 2'd0);
      end else begin : g_keep
         assign clr = 1'b0;
      end

      always_ff @(posedge clk) begin
         if (hdr_we) lane_q[hdr_addr] <= hdr_data[8*b +: 8];
         if (hit) lane_q[byte_addr] <= byte_data;
         else if (clr) lane_q[byte_addr] <= 8'h00;
      end

      assign rd_data[8*b +: 8] = lane_q[rd_addr];
   end

endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
   import rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   input  logic          in_last,
   input  logic          in_crc_err,
   input  logic [1:0]    in_len_err,
   input  logic          rx_en,
   input  logic          flush,
   input  logic [AW:0]   rd_ptr,
   output logic          byte_we,
   output logic [AW-1:0] byte_addr,
   output logic [1:0]    byte_lane,
   output logic [7:0]    byte_data,
   output logic          hdr_we,
   output logic [AW-1:0] hdr_addr,
   output logic [31:0]   hdr_data,
   output logic          commit,
   output logic          wr_busy,
   output logic [AW:0]   wr_ptr
);

   logic          in_frame_q;
   logic          drop_q;
   logic [AW:0]   wptr_q;
   logic [AW:0]   base_q;
   logic [15:0]   idx_q;

   logic          first;
   logic [1:0]    need;
   logic [AW:0]   used;
   logic [AW:0]   base_eff;
   logic [AW:0]   data_ptr;
   logic [AW+1:0] occ_next;
   logic          space_ok;
   logic          accept;
   logic          drop_now;
   logic [15:0]   len_new;

   always_comb begin
      first    = !in_frame_q;
      base_eff = first ? wptr_q : base_q;
      need     = first ? 2'd2 : ((idx_q[1:0] == 2'd0) ? 2'd1 : 2'd0);
      used     = wptr_q - rd_ptr;
      occ_next = {1'b0, used} + {{AW{1'b0}}, need};
      space_ok = occ_next <= (AW+2)'(DEPTH);
      accept   = in_valid && !drop_q && (in_frame_q || rx_en) && space_ok;
      drop_now = in_valid && !drop_q && !accept;
      data_ptr = base_eff + (AW+1)'(1) + (AW+1)'(idx_q >> 2);
      len_new  = idx_q + 16'd1;
   end

   assign byte_we   = accept && !flush;
   assign byte_addr = data_ptr[AW-1:0];
   assign byte_lane = idx_q[1:0];
   assign byte_data = in_byte;
   assign hdr_we    = accept && in_last && !flush;
   assign hdr_addr  = base_eff[AW-1:0];
   assign hdr_data  = {rxq_status(in_crc_err, in_len_err), len_new};
   assign commit    = hdr_we;
   assign wr_busy   = in_frame_q;
   assign wr_ptr    = wptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         drop_q     <= 1'b0;
         wptr_q     <= '0;
         base_q     <= '0;
         idx_q      <= '0;
      end else if (flush) begin
         in_frame_q <= 1'b0;
         drop_q     <= (in_frame_q || drop_q || in_valid) && !(in_valid && in_last);
         wptr_q     <= '0;
         base_q     <= '0;
         idx_q      <= '0;
      end else if (drop_q) begin
         if (in_valid && in_last) drop_q <= 1'b0;
      end else if (accept) begin
         wptr_q <= wptr_q + (AW+1)'(need);
         if (in_last) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
            base_q     <= wptr_q + (AW+1)'(need);
         end else begin
            in_frame_q <= 1'b1;
            idx_q      <= len_new;
            base_q     <= base_eff;
         end
      end else if (drop_now) begin
         wptr_q     <= base_eff;
         in_frame_q <= 1'b0;
         idx_q      <= '0;
         drop_q     <= !in_last;
      end
   end

endmodule

// File: rtl/rxq_rd_seq.sv
module rxq_rd_seq
   import rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          rd_stb,
   input  logic          avail,
   input  logic [31:0]   mem_rdata,
   output logic [AW-1:0] rd_addr,
   output logic [31:0]   rd_word,
   output logic          frame_done,
   output logic [AW:0]   rd_ptr
);

   rxq_phase_e  phase_q;
   logic [AW:0] rptr_q;
   logic [14:0] left_q;
   logic [16:0] len_sum;
   logic        step;

   assign len_sum    = {1'b0, mem_rdata[15:0]} + 17'd3;
   assign step       = rd_stb && avail && !flush;
   assign rd_addr    = rptr_q[AW-1:0];
   assign rd_ptr     = rptr_q;
   assign frame_done = step && (phase_q == PH_DATA) && (left_q == 15'd1);

   always_comb begin
      if (!avail) rd_word = '0;
      else if (phase_q == PH_SYNC) rd_word = RXQ_SYNC_WORD;
      else rd_word = mem_rdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         phase_q <= PH_SYNC;
         rptr_q  <= '0;
         left_q  <= '0;
      end else if (step) begin
         case (phase_q)
            PH_SYNC: phase_q <= PH_HDR;
            PH_HDR: begin
               rptr_q  <= rptr_q + (AW+1)'(1);
               left_q  <= len_sum[16:2];
               phase_q <= PH_DATA;
            end
            PH_DATA: begin
               rptr_q <= rptr_q + (AW+1)'(1);
               left_q <= left_q - 15'd1;
               if (left_q == 15'd1) phase_q <= PH_SYNC;
            end
            default: phase_q <= PH_SYNC;
         endcase
      end
   end

endmodule

// File: rtl/rxq_readout.sv
module rxq_readout
   import rxq_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter int PAD_ZERO = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   input  logic        in_last,
   input  logic        in_crc_err,
   input  logic [1:0]  in_len_err,
   input  logic [1:0]  host_addr,
   input  logic        host_rd,
   input  logic        host_wr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH / 2 + 1);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_readout: DEPTH must be a power of two of at least 4");
   end
   if (PAD_ZERO != 0 && PAD_ZERO != 1) begin : g_bad_pad
      $error("rxq_readout: PAD_ZERO must be 0 or 1");
   end

   logic          rx_en_q;
   logic          flush_busy;
   logic [CW-1:0] frame_cnt;
   logic          ctrl_wr;
   logic          cnt_clr;
   logic          data_rd;

   logic          byte_we, hdr_we, commit, wr_busy, frame_done;
   logic [AW-1:0] byte_addr, hdr_addr, rd_addr;
   logic [1:0]    byte_lane;
   logic [7:0]    byte_data;
   logic [31:0]   hdr_data, mem_rdata, seq_word;
   logic [AW:0]   wr_ptr, rd_ptr;
   logic          unused_wdata;

   assign ctrl_wr      = host_wr && (host_addr == SEL_CTRL);
   assign cnt_clr      = host_wr && (host_addr == SEL_COUNT) && (host_wdata == 32'd0);
   assign data_rd      = host_rd && (host_addr == SEL_DATA);
   assign unused_wdata = ^host_wdata[31:4] ^ ^host_wdata[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en_q    <= 1'b0;
         flush_busy <= 1'b0;
      end else begin
         if (ctrl_wr) rx_en_q <= host_wdata[CTRL_EN_BIT];
         flush_busy <= ctrl_wr && host_wdata[CTRL_FLUSH_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush_busy || cnt_clr) frame_cnt <= '0;
      else if (commit && !frame_done) frame_cnt <= frame_cnt + CW'(1);
      else if (frame_done && !commit) frame_cnt <= frame_cnt - CW'(1);
   end

   rxq_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk, .rst_n, .in_valid, .in_byte, .in_last, .in_crc_err, .in_len_err,
      .rx_en(rx_en_q), .flush(flush_busy), .rd_ptr,
      .byte_we, .byte_addr, .byte_lane, .byte_data,
      .hdr_we, .hdr_addr, .hdr_data, .commit, .wr_busy, .wr_ptr
   );

   rxq_mem #(.DEPTH(DEPTH), .PAD_ZERO(PAD_ZERO)) u_mem (
      .clk, .byte_we, .byte_addr, .byte_lane, .byte_data,
      .hdr_we, .hdr_addr, .hdr_data, .rd_addr, .rd_data(mem_rdata)
   );

   rxq_rd_seq #(.DEPTH(DEPTH)) u_rd (
      .clk, .rst_n, .flush(flush_busy), .rd_stb(data_rd),
      .avail(frame_cnt != '0), .mem_rdata, .rd_addr,
      .rd_word(seq_word), .frame_done, .rd_ptr
   );

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         SEL_CTRL: begin
            host_rdata[CTRL_EN_BIT]    = rx_en_q;
            host_rdata[CTRL_FLUSH_BIT] = flush_busy;
         end
         SEL_COUNT: host_rdata = 32'(frame_cnt);
         SEL_DATA:  host_rdata = seq_word;
         default:   host_rdata = '0;
      endcase
   end

endmodule

// File: rtl/rxq_readout_chk.sv
module rxq_readout_chk #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH / 2 + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_rd,
   input logic [1:0]    host_addr,
   input logic [31:0]   host_rdata,
   input logic [CW-1:0] frame_cnt,
   input logic          flush_busy,
   input logic          cnt_clr,
   input logic          commit,
   input logic          wr_busy,
   input logic          rx_en_q,
   input logic [AW:0]   wr_ptr,
   input logic [AW:0]   rd_ptr
);

   logic [AW:0] occ;
   assign occ = wr_ptr - rd_ptr;

   // R6: an empty queue yields zero on the data register
   p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 2'd2 && frame_cnt == '0) |-> (host_rdata == 32'd0));

   // R7: flush indication lasts one cycle and empties the count
   p_flush_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |=> (!flush_busy || $past(flush_busy) == 1'b0) && frame_cnt == '0);

   // R4: count moves by at most one per cycle outside clear and flush
   p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_busy && !cnt_clr) |=> (frame_cnt == $past(frame_cnt) ||
                                     frame_cnt == $past(frame_cnt) + 1'b1 ||
                                     frame_cnt == $past(frame_cnt) - 1'b1));

   // R4: never more frames than the store could hold
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_cnt <= CW'(DEPTH / 2));

   // R9: the occupied span never exceeds the store
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= (AW+1)'(DEPTH));

   // R8: a frame can only complete if it started with reception enabled
   p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (wr_busy || rx_en_q));

endmodule

bind rxq_readout rxq_readout_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr(host_addr),
   .host_rdata(host_rdata), .frame_cnt(frame_cnt), .flush_busy(flush_busy),
   .cnt_clr(cnt_clr), .commit(commit), .wr_busy(wr_busy), .rx_en_q(rx_en_q),
   .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/tb_rxq_readout.sv
module tb_rxq_readout;

   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_last = 1'b0;
   logic        in_crc_err = 1'b0;
   logic [1:0]  in_len_err = '0;
   logic [1:0]  host_addr = '0;
   logic        host_rd = 1'b0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rxq_readout #(.DEPTH(DEPTH), .PAD_ZERO(1)) dut (
      .clk, .rst_n, .in_valid, .in_byte, .in_last, .in_crc_err, .in_len_err,
      .host_addr, .host_rd, .host_wr, .host_wdata, .host_rdata
   );

   function automatic logic [7:0] bval(input int seed, input int k);
      return 8'((seed + k * 13 + (k >> 3)) & 255);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic host_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      host_rd   = 1'b1;
      #1 d = host_rdata;
      @(posedge clk);
      #1 host_rd = 1'b0;
   endtask

   task automatic host_write(input logic [1:0] a, input logic [31:0] v);
      @(negedge clk);
      host_addr  = a;
      host_wdata = v;
      host_wr    = 1'b1;
      @(posedge clk);
      #1 host_wr = 1'b0;
   endtask

   task automatic drive_bytes(input int seed, input int from, input int upto, input int len,
                              input bit crc, input bit [1:0] le);
      for (int k = from; k <= upto; k++) begin
         @(negedge clk);
         in_valid   = 1'b1;
         in_byte    = bval(seed, k);
         in_last    = (k == len - 1);
         in_crc_err = crc;
         in_len_err = le;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic send_frame(input int len, input int seed, input bit crc, input bit [1:0] le);
      drive_bytes(seed, 0, len - 1, len, crc, le);
   endtask

   task automatic expect_count(input int n, input string req);
      logic [31:0] d;
      host_read(2'd1, d);
      chk(req, d, 32'(n));
   endtask

   task automatic check_frame(input int len, input int seed, input bit crc, input bit [1:0] le,
                              input string tag);
      logic [31:0] d;
      logic [31:0] e;
      host_read(2'd2, d);
      chk({"R1 sync ", tag}, d, 32'h0143414D);
      host_read(2'd2, d);
      chk({"R2 header ", tag}, d, {9'b0, le, crc, 4'b0, 16'(len)});
      for (int w = 0; w < (len + 3) / 4; w++) begin
         for (int b = 0; b < 4; b++)
            e[8*b +: 8] = (4 * w + b < len) ? bval(seed, 4 * w + b) : 8'h00;
         host_read(2'd2, d);
         chk({"R3 payload ", tag}, d, e);
      end
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      host_read(2'd0, d);  chk("R8 reset control", d, 32'h0);
      expect_count(0, "R4 reset count");
      host_read(2'd2, d);  chk("R6 reset data", d, 32'h0);

      host_write(2'd0, 32'h4);
      host_read(2'd0, d);  chk("R8 enable readback", d, 32'h4);

      // R6: empty read does not move readout
      host_read(2'd2, d);  chk("R6 empty read", d, 32'h0);
      host_read(2'd2, d);  chk("R6 empty read again", d, 32'h0);
      send_frame(3, 40, 1'b0, 2'd0);
      check_frame(3, 40, 1'b0, 2'd0, "after empty reads R6");

      // sweep all lengths, with wrap (R3, R10)
      for (int len = 1; len <= 24; len++) begin
         send_frame(len, len * 7, len[0], 2'(len >> 1));
         expect_count(1, "R4 count after store");
         check_frame(len, len * 7, len[0], 2'(len >> 1), "sweep R10");
         expect_count(0, "R4 count after drain");
      end

      // R10: several frames in order
      send_frame(5, 1, 1'b1, 2'd0);
      send_frame(9, 2, 1'b0, 2'd3);
      send_frame(2, 3, 1'b0, 2'd1);
      expect_count(3, "R4 three pending");
      check_frame(5, 1, 1'b1, 2'd0, "order a R10");
      expect_count(2, "R4 after first drain");
      check_frame(9, 2, 1'b0, 2'd3, "order b R10");
      check_frame(2, 3, 1'b0, 2'd1, "order c R10");

      // R9: fill store, drop at start and mid-frame
      for (int i = 0; i < 4; i++) send_frame(12, 100 + i, 1'b0, 2'd0);
      expect_count(4, "R9 store full");
      send_frame(1, 55, 1'b0, 2'd0);
      expect_count(4, "R9 drop at start");
      check_frame(12, 100, 1'b0, 2'd0, "full 0 R9");
      send_frame(8, 60, 1'b0, 2'd0);
      expect_count(4, "R9 reuse freed space");
      check_frame(12, 101, 1'b0, 2'd0, "full 1 R9");
      send_frame(30, 70, 1'b1, 2'd2);
      expect_count(3, "R9 drop mid-frame");
      send_frame(4, 80, 1'b0, 2'd0);
      expect_count(4, "R9 rollback reuse");
      check_frame(12, 102, 1'b0, 2'd0, "full 2 R9");
      check_frame(12, 103, 1'b0, 2'd0, "full 3 R9");
      check_frame(8, 60, 1'b0, 2'd0, "reused R9");
      check_frame(4, 80, 1'b0, 2'd0, "after rollback R9");
      expect_count(0, "R9 all drained");

      // R8: disabled reception drops frames
      host_write(2'd0, 32'h0);
      send_frame(5, 90, 1'b0, 2'd0);
      expect_count(0, "R8 disabled drop");
      host_write(2'd0, 32'h4);
      send_frame(5, 91, 1'b0, 2'd0);
      expect_count(1, "R8 re-enabled");
      check_frame(5, 91, 1'b0, 2'd0, "re-enabled R8");

      // R5: count clear
      send_frame(4, 20, 1'b0, 2'd0);
      host_write(2'd1, 32'd5);
      expect_count(1, "R5 nonzero write ignored");
      host_write(2'd1, 32'd0);
      expect_count(0, "R5 zero write clears");
      host_read(2'd2, d);  chk("R6 read after clear", d, 32'h0);

      // R7: flush
      send_frame(6, 30, 1'b0, 2'd0);
      host_write(2'd0, 32'hC);
      host_read(2'd0, d);  chk("R7 flush bit set", d, 32'hC);
      host_read(2'd0, d);  chk("R7 flush bit cleared", d, 32'h4);
      expect_count(0, "R7 count after flush");
      host_read(2'd2, d);  chk("R7 data after flush", d, 32'h0);

      // R7: flush in the middle of a frame discards its tail
      drive_bytes(33, 0, 2, 6, 1'b0, 2'd0);
      host_write(2'd0, 32'hC);
      drive_bytes(33, 3, 5, 6, 1'b0, 2'd0);
      expect_count(0, "R7 partial frame discarded");
      send_frame(6, 34, 1'b1, 2'd1);
      expect_count(1, "R7 frame after flush");
      check_frame(6, 34, 1'b1, 2'd1, "after flush R7");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule